// File: doc/BRIEF.md
# Asynchronous Strobe-Handshake Register Bus Slave

This block lets an external processor reach an internal register space over an asynchronous bus with separate address and data strobes and a read/write select. All strobes are asynchronous to the local system clock. The block passes them through two-flop synchronisers and finds their edges on the synchronised copies. It holds the address supplied by the master and turns each bus cycle into one request on a simple internal register port. That port answers with a ready pulse and may insert any number of wait states.

A bus cycle works as follows. The master presents an address with chip select low and pulses the address strobe low. The rising edge of that strobe captures the address. The master then drops the data strobe. The level of read/write at that moment decides the direction. The slave holds its active-low acknowledge high until the register port has answered, so the master keeps the cycle open. Once acknowledge falls, the master completes the cycle and raises the data strobe, and acknowledge is then released. On reads the slave drives the shared data bus only while the data bus enable input is low.

The controller has three states:
- `ST_IDLE`: waiting for a cycle.
- `ST_ISSUE`: the request is held on the register port.
- `ST_DONE`: acknowledge is asserted.

It has three transitions:
- START (`ST_IDLE`→`ST_ISSUE`): a synchronised data-strobe fall while chip select is low.
- GRANT (`ST_ISSUE`→`ST_DONE`): the register port reports ready.
- RELEASE (`ST_DONE`→`ST_IDLE`): the synchronised data strobe is seen high.

Top module: `mbus_slave`

## Requirements
- R1: The address is captured into a holding register on the synchronised rising edge of the address strobe while chip select is low. Address input changes after that capture have no effect on the cycle's register address.
- R2: While chip select is high, a data strobe fall starts no cycle: no request is issued and acknowledge stays high.
- R3: A synchronised data strobe fall with chip select low starts a cycle. Read/write high (1) at that point makes it a read (`reg_we_o`=0); low (0) makes it a write (`reg_we_o`=1).
- R4: The request stays high until ready is seen, for any number of wait states. Address, write flag and write data stay stable while it is pending.
- R5: Acknowledge (active low) goes low exactly one clock after the clock in which ready was sampled high with a request pending. It is never low while a request is pending.
- R6: Acknowledge stays low while the data strobe stays low. After the data strobe rises, acknowledge returns high on the third clock edge, and not earlier.
- R7: Write data is sampled from the data bus when the write request is issued and is presented on `reg_wdata_o`.
- R8: On a read, the register read data captured with ready is driven onto the data bus from acknowledge assertion until the data strobe rises. The bus is not driven before acknowledge.
- R9: The data bus is released to high impedance whenever chip select is high, the data strobe is high, the cycle is a write, or data bus enable is high.
- R10: After reset, acknowledge is high, no request is pending and the data bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 15 | Register address from the master |
| bus_data_io | inout | 8 | Shared bidirectional data bus |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_as_n | input | 1 | Address strobe, active low, captures on rising edge |
| bus_ds_n | input | 1 | Data strobe, active low, starts cycle on falling edge |
| bus_rw_i | input | 1 | 1 = read, 0 = write |
| bus_dben_n | input | 1 | Data bus enable for reads, active low |
| bus_ack_n | output | 1 | Cycle acknowledge, active low |
| reg_req_o | output | 1 | Register port request |
| reg_we_o | output | 1 | Register port write flag |
| reg_addr_o | output | 15 | Register port address |
| reg_wdata_o | output | 8 | Register port write data |
| reg_rdata_i | input | 8 | Register port read data |
| reg_ready_i | input | 1 | Register port completion |

## Verification
The bench sweeps a walking-one address set, in both directions, against zero to three wait states. It scrambles the address inputs after the address strobe. A slave that sampled the address late would then request the scrambled location. A slave that counted wait states wrongly would acknowledge early or drop the request. The bench keeps the data strobe low for extra cycles and times acknowledge release to the clock. A slave that released on a fixed timeout, or before seeing the strobe high, would fail there. Data strobe pulses with chip select high, and reads with data bus enable high, catch a slave that ignores chip select or drives the bus when it must not.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } mbs_state_e;
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
    import mbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ds_high,
    input  logic rw_s,
    input  logic ready,
    output logic req,
    output logic is_write,
    output logic ack_n,
    output logic issue,
    output logic grant
);
    mbs_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)   state_d = ST_ISSUE;
            ST_ISSUE: if (ready)   state_d = ST_DONE;
            ST_DONE:  if (ds_high) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            is_write <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) is_write <= ~rw_s;
        end
    end

    always_comb begin
        req   = (state_q == ST_ISSUE);
        ack_n = (state_q != ST_DONE);
        issue = (state_q == ST_IDLE) && start;
        grant = (state_q == ST_ISSUE) && ready;
    end
endmodule

// File: rtl/mbus_slave.sv
module mbus_slave #(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    inout  wire  [DATA_W-1:0] bus_data_io,
    input  logic              bus_cs_n,
    input  logic              bus_as_n,
    input  logic              bus_ds_n,
    input  logic              bus_rw_i,
    input  logic              bus_dben_n,
    output logic              bus_ack_n,
    output logic              reg_req_o,
    output logic              reg_we_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    input  logic              reg_ready_i
);
    localparam int NSTROBE = 4;

    logic [NSTROBE-1:0] strobe_s;
    logic cs_s, as_s, ds_s, rw_s;
    logic as_d, ds_d;
    logic issue, grant;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic drive_en;

    mbs_sync #(.W(NSTROBE), .STAGES(SYNC_DEPTH), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bus_cs_n, bus_as_n, bus_ds_n, bus_rw_i}),
        .q(strobe_s)
    );
    assign {cs_s, as_s, ds_s, rw_s} = strobe_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_d <= 1'b1;
            ds_d <= 1'b1;
        end else begin
            as_d <= as_s;
            ds_d <= ds_s;
        end
    end

    mbs_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start(ds_d & ~ds_s & ~cs_s),
        .ds_high(ds_s),
        .rw_s(rw_s),
        .ready(reg_ready_i),
        .req(reg_req_o),
        .is_write(reg_we_o),
        .ack_n(bus_ack_n),
        .issue(issue),
        .grant(grant)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (as_s & ~as_d & ~cs_s) addr_q <= bus_addr_i;
            if (issue & ~rw_s) wdata_q <= bus_data_io;
            if (grant) rdata_q <= reg_rdata_i;
        end
    end

    assign reg_addr_o  = addr_q;
    assign reg_wdata_o = wdata_q;

    assign drive_en    = ~bus_ack_n & ~reg_we_o & ~bus_cs_n & ~bus_ds_n & ~bus_dben_n;
    assign bus_data_io = drive_en ? rdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/mbs_chk.sv
module mbs_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req_o,
    input logic              reg_ready_i,
    input logic              reg_we_o,
    input logic [ADDR_W-1:0] reg_addr_o,
    input logic [DATA_W-1:0] reg_wdata_o,
    input logic              bus_ack_n,
    input logic              bus_cs_n,
    input logic              bus_ds_n,
    input logic              bus_dben_n,
    input logic              drive_en
);
    // R5
    ack_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack_n) |-> $past(reg_ready_i && reg_req_o));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && !reg_ready_i) |=> (reg_req_o && $stable(reg_addr_o)
            && $stable(reg_we_o) && $stable(reg_wdata_o)));

    // R5
    no_req_during_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req_o && !bus_ack_n));

    // R6
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ack_n && !bus_ds_n && $past(!bus_ds_n) && $past(!bus_ds_n, 2)) |=> !bus_ack_n);

    // R9
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (!bus_cs_n && !bus_ds_n && !bus_dben_n && !bus_ack_n && !reg_we_o));
endmodule

bind mbus_slave mbs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_req_o(reg_req_o), .reg_ready_i(reg_ready_i), .reg_we_o(reg_we_o),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .bus_ack_n(bus_ack_n), .bus_cs_n(bus_cs_n), .bus_ds_n(bus_ds_n),
    .bus_dben_n(bus_dben_n), .drive_en(drive_en)
);

// File: tb/tb_mbus_slave.sv
module tb_mbus_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] addr = '0;
    logic        cs_n = 1'b1, as_n = 1'b1, ds_n = 1'b1, rw = 1'b1, dben_n = 1'b0;
    logic        tb_en = 1'b0;
    logic [7:0]  tb_drv = '0;
    wire  [7:0]  bus;
    logic        ack_n, req, we, ready = 1'b0;
    logic [14:0] raddr;
    logic [7:0]  wdata, rdata;

    int checks = 0, errors = 0;
    int ws = 0, nreq = 0;
    logic [14:0] last_addr;
    logic        last_we;
    logic [7:0]  last_wdata;

    always #2 clk = ~clk;

    assign bus = tb_en ? tb_drv : 8'hzz;
    for (genvar g = 0; g < 8; g++) begin : g_pu
        pullup (bus[g]);
    end

    function automatic logic [7:0] fdat(input logic [14:0] a);
        return {1'b0, a[6:0] ^ a[13:7]};
    endfunction
    assign rdata = fdat(raddr);

    mbus_slave dut (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_data_io(bus),
        .bus_cs_n(cs_n), .bus_as_n(as_n), .bus_ds_n(ds_n), .bus_rw_i(rw),
        .bus_dben_n(dben_n), .bus_ack_n(ack_n), .reg_req_o(req), .reg_we_o(we),
        .reg_addr_o(raddr), .reg_wdata_o(wdata), .reg_rdata_i(rdata),
        .reg_ready_i(ready)
    );

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // register-port responder with ws wait states
    initial begin
        int cnt = 0;
        bit pend = 0;
        forever begin
            @(negedge clk);
            if (pend) begin
                chk(ack_n == 1'b0, "R5 ack one clock after ready", int'(ack_n), 0);
                pend = 0;
            end
            ready = 1'b0;
            if (req) begin
                if (cnt == ws) begin
                    chk(ack_n == 1'b1, "R5 ack high while pending", int'(ack_n), 1);
                    ready = 1'b1;
                    last_addr = raddr; last_we = we; last_wdata = wdata;
                    nreq++; pend = 1; cnt = 0;
                end else cnt++;
            end
        end
    end

    task automatic bus_cycle(input logic [14:0] a, input bit rd, input logic [7:0] wd,
                             input bit den_hi, input int extra);
        int n0, t;
        @(negedge clk);
        cs_n = 0; addr = a; as_n = 0; rw = rd; dben_n = den_hi;
        repeat (3) @(negedge clk);
        as_n = 1;
        repeat (4) @(negedge clk);
        addr = ~a;                       // R1: late address change ignored
        if (!rd) begin tb_en = 1; tb_drv = wd; end
        n0 = nreq;
        ds_n = 0;
        @(negedge clk);
        if (rd) chk(bus == 8'hFF, "R8 bus idle before ack", int'(bus), 8'hFF);
        t = 0;
        while (ack_n && t < 60) begin @(negedge clk); t++; end
        chk(ack_n == 1'b0, "R4 cycle acknowledged after wait states", int'(ack_n), 0);
        chk(nreq == n0 + 1, "R3 one request per cycle", nreq, n0 + 1);
        chk(last_addr == a, "R1 captured address", int'(last_addr), int'(a));
        chk(last_we == !rd, "R3 direction", int'(last_we), int'(!rd));
        if (!rd) chk(last_wdata == wd, "R7 write data", int'(last_wdata), int'(wd));
        if (rd && !den_hi) chk(bus == fdat(a), "R8 read data on bus", int'(bus), int'(fdat(a)));
        if (rd && den_hi) chk(bus == 8'hFF, "R9 released with dben high", int'(bus), 8'hFF);
        for (int i = 0; i < extra; i++) begin
            @(negedge clk);
            chk(ack_n == 1'b0, "R6 ack held while strobe low", int'(ack_n), 0);
            if (rd && !den_hi) chk(bus == fdat(a), "R8 read data held", int'(bus), int'(fdat(a)));
        end
        @(negedge clk);
        ds_n = 1;
        #1;
        if (rd) chk(bus == 8'hFF, "R9 released on strobe high", int'(bus), 8'hFF);
        @(negedge clk);
        chk(ack_n == 1'b0, "R6 ack not released early (1)", int'(ack_n), 0);
        @(negedge clk);
        chk(ack_n == 1'b0, "R6 ack not released early (2)", int'(ack_n), 0);
        @(negedge clk);
        chk(ack_n == 1'b1, "R6 ack released", int'(ack_n), 1);
        tb_en = 0; cs_n = 1; dben_n = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ack_n == 1'b1, "R10 ack after reset", int'(ack_n), 1);
        chk(req == 1'b0, "R10 no request after reset", int'(req), 0);
        chk(bus == 8'hFF, "R10 bus released after reset", int'(bus), 8'hFF);

        for (int w = 0; w < 4; w++) begin
            ws = w;
            for (int b = 0; b < 15; b++) begin
                logic [14:0] a;
                a = 15'(1 << b) ^ 15'(w * 3);
                bus_cycle(a, 1'b1, 8'h00, 1'b0, (b % 3 == 0) ? 5 : 0);
                bus_cycle(a, 1'b0, 8'((b * 17 + w * 5) ^ 8'hA5), 1'b0, (b % 4 == 1) ? 3 : 0);
            end
            bus_cycle(15'h7FFF ^ 15'(w), 1'b1, 8'h00, 1'b1, 2);
        end

        // R2: strobes with chip select high start nothing
        begin
            int n0;
            n0 = nreq;
            @(negedge clk);
            cs_n = 1; addr = 15'h1234; as_n = 0;
            repeat (3) @(negedge clk);
            as_n = 1;
            repeat (3) @(negedge clk);
            ds_n = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                chk(ack_n == 1'b1 && req == 1'b0, "R2 no cycle with cs high",
                    int'({req, ack_n}), 1);
            end
            ds_n = 1;
            repeat (4) @(negedge clk);
            chk(nreq == n0, "R2 no request counted", nreq, n0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule